// File: doc/BRIEF.md
# Quadrature Position Counter

This block keeps a signed 32-bit position count from three slow external pins: two count pins (A and B) and one marker pin (Z). The count pins can be decoded in four ways. They can be read as a Gray-coded quadrature pair with 4x resolution, or as a 2-bit binary code. They can also drive a plain up/down counter, where A's rising edge counts and B's level gives the direction, or where A's rising edge counts up and B's rising edge counts down. Each pin is brought into the clock domain by a two-flop synchronizer. It then passes a debounce filter that accepts a new level only once that level has held for 2^N clocks.

The marker pin gives a push-button event. It can also, when enabled, clear the count. Two signed bound registers watch every step. A step that would move the count above the upper bound or below the lower bound raises a one-cycle interrupt. When auto-zero is enabled, that step loads zero instead. Each accepted step also produces a one-cycle event strobe with its direction, so an external timer can measure the time between steps. Software uses a small word-wide write port with a combinational read port.

Register map (regAddr): 0 = config, 1 = count, 2 = upper bound, 3 = lower bound, 4 = status. Config fields: [1:0] decode mode (0 quadrature, 1 binary, 2 direction-level, 3 up/down edges), [5:2] debounce exponent N, [6] marker clears count, [7] auto-zero on bound. Status bit 0 is the sticky code error flag.

Top module: `quad_counter`

## Requirements
- R1: After reset the count, config and status read 0, the upper bound reads 0x7FFFFFFF, the lower bound reads 0x80000000, and every strobe and interrupt output is low.
- R2: Writes to addresses 0 to 3 are read back unchanged (config in bits [7:0]). A write to address 1 loads the count directly.
- R3: In mode 0 the pins form code {A,B}. The up order is 00, 01, 11, 10, 00. Every single-bit change moves the count by one in that order's direction.
- R4: In modes 0 and 1, a code change that cannot be one step leaves the count unchanged and sets status bit 0 (also on quadErr). The flag stays set until any write to address 4.
- R5: In mode 1, {A,B} is a binary value with A as the MSB. A change of +1 modulo 4 counts up, and a change of -1 modulo 4 counts down.
- R6: In mode 2, each rising edge of A counts one step, up when B is high and down when B is low. Changes of B alone do not count.
- R7: In mode 3, a rising edge of A counts up and a rising edge of B counts down. Simultaneous rising edges cancel and leave the count unchanged.
- R8: A pin level is accepted only after the synchronized pin has held it for 2^N consecutive clocks. A pulse of 2^N-1 clocks is ignored.
- R9: A rising edge of the filtered Z pin pulses irqZero for one cycle. With config bit 6 set, it also clears the count, and this takes priority over a step in the same cycle.
- R10: A step whose result is signed-greater than the upper bound pulses irqUpper, and one whose result is signed-less than the lower bound pulses irqLower. Equal values raise nothing. With config bit 7 set, such a step loads 0.
- R11: Each accepted step pulses countEvt for one cycle, in the cycle the count takes its new value, with countUp giving its direction. Without an event, marker clear or count write, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinA | input | 1 | Count pin A (asynchronous) |
| pinB | input | 1 | Count pin B (asynchronous) |
| pinZ | input | 1 | Marker / push-button pin (asynchronous) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| countEvt | output | 1 | One-cycle strobe per accepted step |
| countUp | output | 1 | Direction of the last step (1 = up) |
| irqUpper | output | 1 | Upper bound passed |
| irqLower | output | 1 | Lower bound passed |
| irqZero | output | 1 | Marker pin rising edge |
| quadErr | output | 1 | Sticky illegal-code flag |

## Verification
The step-size and hold assertions assume that a count write and a filtered pin step never land in the same cycle. They also assume that the configuration is not rewritten while a filtered edge is still in the pipeline, since the checked relations use the configuration of the previous cycle. The stimulus keeps within this: it changes a pin only at a falling clock edge, holds each level for at least 2^N plus eight clocks, and touches registers only while all pins are quiet. The quadrature and binary sweeps cover all sixteen previous/next code pairs. Each expected delta is computed from the code position modulo 4.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_BIN  = 2'd1,
    MODE_DIR  = 2'd2,
    MODE_EDGE = 2'd3
  } countMode_e;

  // strobes from the decode control to the count datapath
  typedef struct packed {
    logic step;
    logic up;
    logic err;
    logic zero;
  } stepCmd_t;

  localparam int CFG_W = 8;
  localparam logic [2:0] ADDR_CFG   = 3'd0;
  localparam logic [2:0] ADDR_COUNT = 3'd1;
  localparam logic [2:0] ADDR_UPPER = 3'd2;
  localparam logic [2:0] ADDR_LOWER = 3'd3;
  localparam logic [2:0] ADDR_STAT  = 3'd4;
endpackage

// File: rtl/qc_filter.sv
module qc_filter #(
  parameter int DB_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawIn,
  input  logic [3:0] logN,
  output logic       clean
);
  logic [1:0]      syncQ;
  logic            stableQ;
  logic [DB_W-1:0] runQ;
  logic [DB_W-1:0] limit;

  assign limit = (DB_W'(1) << logN) - DB_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      stableQ <= 1'b0;
      runQ    <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == stableQ) begin
        runQ <= '0;
      end else if (runQ == limit) begin
        stableQ <= syncQ[1];
        runQ    <= '0;
      end else begin
        runQ <= runQ + DB_W'(1);
      end
    end
  end

  assign clean = stableQ;
endmodule

// File: rtl/qc_ctrl.sv
module qc_ctrl
  import qc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cleanPins,
  input  countMode_e mode,
  output stepCmd_t   cmd
);
  logic [2:0] oldQ;
  logic [1:0] codeNow, codeOld, flip, diff;
  logic       aRise, bRise;

  always_ff @(posedge clk) begin
    if (!rstN) oldQ <= '0;
    else       oldQ <= cleanPins;
  end

  assign codeNow = {cleanPins[0], cleanPins[1]};
  assign codeOld = {oldQ[0], oldQ[1]};
  assign flip    = codeNow ^ codeOld;
  assign diff    = codeNow - codeOld;
  assign aRise   = cleanPins[0] & ~oldQ[0];
  assign bRise   = cleanPins[1] & ~oldQ[1];

  always_comb begin
    cmd      = '0;
    cmd.zero = cleanPins[2] & ~oldQ[2];
    case (mode)
      MODE_QUAD: begin
        if (flip == 2'b11) cmd.err = 1'b1;
        else if (flip != 2'b00) begin
          cmd.step = 1'b1;
          cmd.up   = oldQ[0] ^ cleanPins[1];
        end
      end
      MODE_BIN: begin
        if (diff == 2'd2) cmd.err = 1'b1;
        else if (diff != 2'd0) begin
          cmd.step = 1'b1;
          cmd.up   = (diff == 2'd1);
        end
      end
      MODE_DIR: begin
        cmd.step = aRise;
        cmd.up   = cleanPins[1];
      end
      default: begin
        cmd.step = aRise ^ bRise;
        cmd.up   = aRise;
      end
    endcase
  end
endmodule

// File: rtl/qc_datapath.sv
module qc_datapath
  import qc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         cmd,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic [CFG_W-1:0] cfgOut,
  output logic [CNT_W-1:0] countOut,
  output logic             countEvt,
  output logic             countUp,
  output logic             irqUpper,
  output logic             irqLower,
  output logic             irqZero,
  output logic             quadErr
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX_POS = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MIN_NEG = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CFG_W-1:0] cfgQ;
  logic [CNT_W-1:0] countQ, upperQ, lowerQ, nextVal;
  logic             errQ, evtQ, upQ, irqUpQ, irqLoQ, irqZQ;
  logic             overUp, underLo, wrCount;

  assign nextVal = cmd.up ? countQ + ONE : countQ - ONE;
  assign overUp  = $signed(nextVal) > $signed(upperQ);
  assign underLo = $signed(nextVal) < $signed(lowerQ);
  assign wrCount = regWrEn && (regAddr == ADDR_COUNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      countQ <= '0;
      upperQ <= MAX_POS;
      lowerQ <= MIN_NEG;
      errQ   <= 1'b0;
      evtQ   <= 1'b0;
      upQ    <= 1'b0;
      irqUpQ <= 1'b0;
      irqLoQ <= 1'b0;
      irqZQ  <= 1'b0;
    end else begin
      evtQ   <= 1'b0;
      irqUpQ <= 1'b0;
      irqLoQ <= 1'b0;
      irqZQ  <= cmd.zero;
      if (regWrEn && regAddr == ADDR_CFG)   cfgQ   <= regWrData[CFG_W-1:0];
      if (regWrEn && regAddr == ADDR_UPPER) upperQ <= regWrData;
      if (regWrEn && regAddr == ADDR_LOWER) lowerQ <= regWrData;
      if (regWrEn && regAddr == ADDR_STAT)  errQ   <= 1'b0;
      else if (cmd.err)                     errQ   <= 1'b1;
      if (wrCount) begin
        countQ <= regWrData;
      end else if (cmd.zero && cfgQ[6]) begin
        countQ <= '0;
      end else if (cmd.step) begin
        evtQ   <= 1'b1;
        upQ    <= cmd.up;
        irqUpQ <= overUp;
        irqLoQ <= underLo;
        countQ <= (cfgQ[7] && (overUp || underLo)) ? '0 : nextVal;
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CFG:   regRdData = {{(CNT_W-CFG_W){1'b0}}, cfgQ};
      ADDR_COUNT: regRdData = countQ;
      ADDR_UPPER: regRdData = upperQ;
      ADDR_LOWER: regRdData = lowerQ;
      ADDR_STAT:  regRdData = {{(CNT_W-1){1'b0}}, errQ};
      default:    regRdData = '0;
    endcase
  end

  assign cfgOut   = cfgQ;
  assign countOut = countQ;
  assign countEvt = evtQ;
  assign countUp  = upQ;
  assign irqUpper = irqUpQ;
  assign irqLower = irqLoQ;
  assign irqZero  = irqZQ;
  assign quadErr  = errQ;
endmodule

// File: rtl/quad_counter.sv
module quad_counter
  import qc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DB_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinA,
  input  logic             pinB,
  input  logic             pinZ,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic             countEvt,
  output logic             countUp,
  output logic             irqUpper,
  output logic             irqLower,
  output logic             irqZero,
  output logic             quadErr
);
  localparam int NUM_PINS = 3;

  logic [NUM_PINS-1:0] rawPins, cleanPins;
  logic [CFG_W-1:0]    cfgVal;
  logic [CNT_W-1:0]    countVal;
  stepCmd_t            cmd;

  assign rawPins = {pinZ, pinB, pinA};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    qc_filter #(.DB_W(DB_W)) u_flt (
      .clk(clk), .rstN(rstN), .rawIn(rawPins[i]),
      .logN(cfgVal[5:2]), .clean(cleanPins[i])
    );
  end

  qc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cleanPins(cleanPins),
    .mode(countMode_e'(cfgVal[1:0])), .cmd(cmd)
  );

  qc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cfgOut(cfgVal), .countOut(countVal),
    .countEvt(countEvt), .countUp(countUp), .irqUpper(irqUpper),
    .irqLower(irqLower), .irqZero(irqZero), .quadErr(quadErr)
  );
endmodule

// File: rtl/qc_checker.sv
module qc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic [CNT_W-1:0] countVal,
  input logic             zeroClr,
  input logic             autoZero,
  input logic             countEvt,
  input logic             countUp,
  input logic             irqUpper,
  input logic             irqLower,
  input logic             irqZero,
  input logic             quadErr
);
  logic wrCount, wrStat;
  assign wrCount = regWrEn && (regAddr == 3'd1);
  assign wrStat  = regWrEn && (regAddr == 3'd4);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!countEvt && !irqZero && !$past(wrCount)) |-> $stable(countVal));

  assert_unit_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (countEvt && !irqUpper && !irqLower) |->
      (countVal == $past(countVal) + CNT_W'(1) || countVal == $past(countVal) - CNT_W'(1)));

  assert_step_dir_R11: assert property (@(posedge clk) disable iff (!rstN)
    (countEvt && !irqUpper && !irqLower) |->
      (countUp == (countVal == $past(countVal) + CNT_W'(1))));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(quadErr) && !$past(wrStat)) |-> quadErr);

  assert_bound_evt_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqUpper || irqLower) |-> countEvt);

  assert_auto_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((irqUpper || irqLower) && $past(autoZero)) |-> (countVal == '0));

  assert_zero_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqZero && $past(zeroClr) && !$past(wrCount)) |-> (countVal == '0));
endmodule

bind quad_counter qc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .countVal(countVal), .zeroClr(cfgVal[6]), .autoZero(cfgVal[7]),
  .countEvt(countEvt), .countUp(countUp), .irqUpper(irqUpper),
  .irqLower(irqLower), .irqZero(irqZero), .quadErr(quadErr)
);

// File: tb/quad_counter_bench.sv
module quad_counter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinA = 1'b0, pinB = 1'b0, pinZ = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        countEvt, countUp, irqUpper, irqLower, irqZero, quadErr;

  int checks = 0, errors = 0, settle = 8;
  int evtCnt = 0, upCnt = 0, loCnt = 0, zCnt = 0;
  logic lastUp = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_counter u_quad_counter (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB), .pinZ(pinZ),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .countEvt(countEvt), .countUp(countUp),
    .irqUpper(irqUpper), .irqLower(irqLower), .irqZero(irqZero), .quadErr(quadErr)
  );

  always @(posedge clk) if (rstN) begin
    if (countEvt) begin evtCnt++; lastUp = countUp; end
    if (irqUpper) upCnt++;
    if (irqLower) loCnt++;
    if (irqZero)  zCnt++;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdData;
  endtask

  task automatic setCfg(logic [7:0] c, int n);
    wrReg(3'd0, c); settle = (1 << n) + 8;
  endtask

  task automatic setPins(logic a, logic b, logic z);
    @(negedge clk); pinA = a; pinB = b; pinZ = z; tick(settle);
  endtask

  function automatic int gpos(int c);
    case (c) 0: return 0; 1: return 1; 3: return 2; default: return 3; endcase
  endfunction

  task automatic sweep(bit gray, string tag);
    logic [31:0] v;
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        int d, e0;
        setPins(p[1], p[0], 1'b0);
        wrReg(3'd1, 32'd100); wrReg(3'd4, 0); e0 = evtCnt;
        setPins(n[1], n[0], 1'b0);
        d = gray ? ((gpos(n) - gpos(p)) & 3) : ((n - p) & 3);
        rdReg(3'd1, v);
        check({tag, " count"}, v, d == 1 ? 32'd101 : d == 3 ? 32'd99 : 32'd100);
        rdReg(3'd4, v);
        check("R4 error flag", v, (d == 2) ? 32'd1 : 32'd0);
        check("R4 quadErr port", {31'd0, quadErr}, (d == 2) ? 32'd1 : 32'd0);
        check("R11 events per step", evtCnt - e0, (d == 1 || d == 3) ? 32'd1 : 32'd0);
        if (d == 1 || d == 3) check("R11 direction", {31'd0, lastUp}, (d == 1) ? 32'd1 : 32'd0);
      end
    end
    setPins(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    logic [31:0] v;
    int z0, u0, l0;
    tick(3); rstN = 1'b1; tick(2);
    // R1 reset state
    rdReg(3'd0, v); check("R1 config", v, 0);
    rdReg(3'd1, v); check("R1 count", v, 0);
    rdReg(3'd2, v); check("R1 upper", v, 32'h7FFF_FFFF);
    rdReg(3'd3, v); check("R1 lower", v, 32'h8000_0000);
    rdReg(3'd4, v); check("R1 status", v, 0);
    check("R1 outputs", {26'd0, countEvt, countUp, irqUpper, irqLower, irqZero, quadErr}, 0);
    // R2 register access
    wrReg(3'd1, 32'h1234_5678); rdReg(3'd1, v); check("R2 count load", v, 32'h1234_5678);
    wrReg(3'd2, 32'h0000_0ABC); rdReg(3'd2, v); check("R2 upper", v, 32'h0000_0ABC);
    wrReg(3'd3, 32'hFFFF_F000); rdReg(3'd3, v); check("R2 lower", v, 32'hFFFF_F000);
    wrReg(3'd0, 32'hFFFF_FFAD); rdReg(3'd0, v); check("R2 config", v, 32'h0000_00AD);
    wrReg(3'd2, 32'h7FFF_FFFF); wrReg(3'd3, 32'h8000_0000);
    // R3 / R5 sweeps over all code pairs
    setCfg(8'h00, 0); sweep(1'b1, "R3 quadrature");
    setCfg(8'h01, 0); sweep(1'b0, "R5 binary");
    // R6 direction-level mode
    setCfg(8'h02, 0); wrReg(3'd1, 0);
    setPins(0, 1, 0); rdReg(3'd1, v); check("R6 B alone", v, 0);
    for (int i = 0; i < 3; i++) begin setPins(1, 1, 0); setPins(0, 1, 0); end
    rdReg(3'd1, v); check("R6 up pulses", v, 3);
    setPins(0, 0, 0);
    for (int i = 0; i < 2; i++) begin setPins(1, 0, 0); setPins(0, 0, 0); end
    rdReg(3'd1, v); check("R6 down pulses", v, 1);
    // R7 up/down edge mode
    setCfg(8'h03, 0); wrReg(3'd1, 10);
    for (int i = 0; i < 3; i++) begin setPins(1, 0, 0); setPins(0, 0, 0); end
    setPins(0, 1, 0); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R7 edges", v, 12);
    setPins(1, 1, 0); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R7 simultaneous cancel", v, 12);
    // R8 debounce window, N = 3 (8 clocks)
    setCfg(8'h0E, 3); setPins(0, 1, 0); wrReg(3'd1, 0);
    @(negedge clk); pinA = 1'b1; tick(4); pinA = 1'b0; tick(settle);
    rdReg(3'd1, v); check("R8 short glitch", v, 0);
    @(negedge clk); pinA = 1'b1; tick(7); pinA = 1'b0; tick(settle);
    rdReg(3'd1, v); check("R8 one clock short", v, 0);
    @(negedge clk); pinA = 1'b1; tick(8); pinA = 1'b0; tick(settle);
    rdReg(3'd1, v); check("R8 full window", v, 1);
    // R9 marker
    setCfg(8'h02, 0); setPins(0, 0, 0); wrReg(3'd1, 7); z0 = zCnt;
    setPins(0, 0, 1); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R9 marker no clear", v, 7);
    check("R9 irqZero pulse", zCnt - z0, 1);
    setCfg(8'h42, 0); setPins(0, 0, 1); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R9 marker clear", v, 0);
    check("R9 second irqZero", zCnt - z0, 2);
    // R10 bounds
    setCfg(8'h03, 0); wrReg(3'd2, 5); wrReg(3'd3, 32'hFFFF_FFFD);
    u0 = upCnt; l0 = loCnt;
    wrReg(3'd1, 4); setPins(1, 0, 0); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R10 equal upper", v, 5); check("R10 no irq at equal", upCnt - u0, 0);
    setPins(1, 0, 0); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R10 pass upper", v, 6); check("R10 irqUpper", upCnt - u0, 1);
    wrReg(3'd1, 32'hFFFF_FFFD); setPins(0, 1, 0); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R10 pass lower", v, 32'hFFFF_FFFC); check("R10 irqLower", loCnt - l0, 1);
    setCfg(8'h83, 0); wrReg(3'd1, 5); setPins(1, 0, 0); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R10 auto-zero upper", v, 0); check("R10 irqUpper auto", upCnt - u0, 2);
    wrReg(3'd1, 32'hFFFF_FFFD); setPins(0, 1, 0); setPins(0, 0, 0);
    rdReg(3'd1, v); check("R10 auto-zero lower", v, 0); check("R10 irqLower auto", loCnt - l0, 2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule